// File: doc/BRIEF.md
# Double-Buffered 3x4 Colour Matrix

This block is a gamut-remap stage for a pixel stream. Each incoming RGB pixel is multiplied by a 3x4 coefficient matrix. Output channel r is `Kr0*R + Kr1*G + Kr2*B + Kr3`. The fourth column is an additive offset counted in whole pixel LSBs. Each result is rounded and clamped to the pixel range. The datapath is pipelined and has a fixed latency of three cycles. A bypass path is delay-matched to the same latency, so switching modes never reorders or shifts pixels.

Two complete coefficient banks, A and B, sit in host-writable registers with two coefficients packed per word. A control word holds a requested mode (bypass, bank A, bank B) and a coefficient format. The request is applied only at a frame-start pulse. A read-only field reports the mode actually in force. The host reads that field, fills the idle bank, requests it, and the change lands on a frame boundary for all twelve coefficients at once.

Top module: `ccm_matrix`

## Requirements
- R1: After reset every output is 0, the active mode is bypass (0), the requested mode and format are 0, and every coefficient word reads back as 0.
- R2: Coefficient index i = 4*row + col, with row 0 driving red, col 0..2 weighting R, G, B and col 3 the offset. Word k (k = 0..5) holds coefficient 2k in bits [15:0] and 2k+1 in bits [31:16]. Bank A words sit at addresses 0..5 and bank B words at 8..13. `host_rdata` returns the addressed word one clock after the address is presented. Addresses 6, 7 and 15 read 0.
- R3: Mode encoding in the control word (address 14, bits [1:0]): 0 bypass, 1 bank A, 2 bank B. The reserved value 3 behaves as bypass, and the current-mode field then reports 0.
- R4: A written mode or format has no effect until a cycle with `frame_start` high. The current-mode field (address 14, bits [9:8]) updates at that same clock edge. A pixel presented in the `frame_start` cycle is still processed with the previous settings.
- R5: Each non-bypass output equals floor((R*K0 + G*K1 + B*K2 + K3*2^F + 2^(F-1)) / 2^F), which is rounding half up. Coefficients are signed 16-bit values.
- R6: Format bit (address 14, bit 4) 0 gives F = 13 (signed 2.13). Format bit 1 gives F = 12 (signed 3.12).
- R7: Results below 0 give 0 and results above 1023 give 1023.
- R8: Every output pixel appears exactly three clocks after its input, with `pix_valid_o` following `pix_valid_i` by the same delay, in both bypass and matrix modes.
- R9: Writes to the bank that is not active have no effect on the output stream.
- R10: In bypass each output channel equals the corresponding input channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_addr | input | 4 | Host register address (write and read) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered readback of `host_addr` |
| frame_start | input | 1 | Frame boundary pulse; applies requested mode and format |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_r_i | input | 10 | Input red |
| pix_g_i | input | 10 | Input green |
| pix_b_i | input | 10 | Input blue |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_r_o | output | 10 | Output red |
| pix_g_o | output | 10 | Output green |
| pix_b_o | output | 10 | Output blue |

## Verification
The bound checker watches the following on every cycle:
- the three-cycle valid delay;
- bypass pixels passing through unchanged;
- the current-mode field moving only after a frame-start pulse;
- the current-mode field taking the requested value, or bypass when the request is the reserved code.

The rounding arithmetic, the clamping at both ends, the two formats, the packed register layout and the freedom to rewrite the idle bank can only be shown by the bench. It does this by sweeping pixel grids through several matrices and comparing each output against values it computes from the formula.

// File: rtl/ccm_pkg.sv
package ccm_pkg;

  typedef enum logic [1:0] {
    MODE_BYP = 2'd0,
    MODE_A   = 2'd1,
    MODE_B   = 2'd2,
    MODE_RSV = 2'd3
  } ccm_mode_e;

  // matrix shape is the function of the block, not a tuning knob
  localparam int unsigned NROW  = 3;
  localparam int unsigned NCOL  = 4;
  localparam int unsigned NCOEF = NROW * NCOL;

  function automatic ccm_mode_e ccm_effective(input logic [1:0] req);
    ccm_mode_e m;
    case (req)
      2'd1:    m = MODE_A;
      2'd2:    m = MODE_B;
      default: m = MODE_BYP;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/ccm_host_regs.sv
module ccm_host_regs
  import ccm_pkg::*;
#(
  parameter int COEF_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [2*COEF_W-1:0]      wdata,
  input  logic [1:0]               cur_mode,
  output logic [2*COEF_W-1:0]      rdata,
  output logic [NCOEF*COEF_W-1:0]  coef_a,
  output logic [NCOEF*COEF_W-1:0]  coef_b,
  output logic [1:0]               req_mode,
  output logic                     req_fmt
);
  localparam int WORD_W = 2 * COEF_W;
  localparam int NWORDS = NCOEF / 2;
  localparam int WIDX_W = $clog2(NWORDS);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = {1'b1, WIDX_W'(NWORDS)};

  logic              bank_sel;
  logic [WIDX_W-1:0] widx;
  logic              is_word;
  logic              is_ctrl;

  assign bank_sel = addr[WIDX_W];
  assign widx     = addr[WIDX_W-1:0];
  assign is_word  = (32'(widx) < NWORDS);
  assign is_ctrl  = (addr == CTRL_ADDR);

  logic [WORD_W-1:0]       bank_rd   [2];
  logic [NCOEF*COEF_W-1:0] bank_flat [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [WORD_W-1:0] mem_q [NWORDS];

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int w = 0; w < NWORDS; w++) mem_q[w] <= '0;
      end else if (wr_en && is_word && (bank_sel == 1'(b))) begin
        mem_q[widx] <= wdata;
      end
    end

    assign bank_rd[b] = is_word ? mem_q[widx] : '0;

    for (genvar w = 0; w < NWORDS; w++) begin : g_flat
      assign bank_flat[b][w*WORD_W +: WORD_W] = mem_q[w];
    end
  end

  assign coef_a = bank_flat[0];
  assign coef_b = bank_flat[1];

  logic [1:0] req_mode_q;
  logic       req_fmt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_mode_q <= 2'd0;
      req_fmt_q  <= 1'b0;
    end else if (wr_en && is_ctrl) begin
      req_mode_q <= wdata[1:0];
      req_fmt_q  <= wdata[4];
    end
  end

  assign req_mode = req_mode_q;
  assign req_fmt  = req_fmt_q;

  logic [WORD_W-1:0] ctrl_word;
  assign ctrl_word = WORD_W'({cur_mode, 3'b000, req_fmt_q, 2'b00, req_mode_q});

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (is_ctrl) rdata <= ctrl_word;
    else if (is_word) rdata <= bank_rd[bank_sel];
    else rdata <= '0;
  end

endmodule

// File: rtl/ccm_mode_sync.sv
module ccm_mode_sync
  import ccm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      frame_start,
  input  logic [1:0] req_mode,
  input  logic      req_fmt,
  output ccm_mode_e act_mode,
  output logic      act_fmt
);
  // settings move only on a frame boundary so a frame never mixes banks
  always_ff @(posedge clk) begin
    if (rst) begin
      act_mode <= MODE_BYP;
      act_fmt  <= 1'b0;
    end else if (frame_start) begin
      act_mode <= ccm_effective(req_mode);
      act_fmt  <= req_fmt;
    end
  end

endmodule

// File: rtl/ccm_mac_row.sv
module ccm_mac_row
  import ccm_pkg::*;
#(
  parameter int PIX_W   = 10,
  parameter int COEF_W  = 16,
  parameter int FRAC_F0 = 13,
  parameter int FRAC_F1 = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_byp,
  input  logic                   in_fmt,
  input  logic [PIX_W-1:0]       r_i,
  input  logic [PIX_W-1:0]       g_i,
  input  logic [PIX_W-1:0]       b_i,
  input  logic [PIX_W-1:0]       own_i,
  input  logic [NCOL*COEF_W-1:0] coef_i,
  output logic [PIX_W-1:0]       pix_o
);
  localparam int PROD_W = PIX_W + 1 + COEF_W;
  localparam int ACC_W  = PROD_W + 3;
  localparam logic signed [ACC_W-1:0] PIX_MAX = ACC_W'((1 << PIX_W) - 1);
  localparam logic signed [ACC_W-1:0] RND0    = ACC_W'(1 << (FRAC_F0 - 1));
  localparam logic signed [ACC_W-1:0] RND1    = ACC_W'(1 << (FRAC_F1 - 1));

  logic [PIX_W-1:0]         chan [NCOL-1];
  logic signed [COEF_W-1:0] cf   [NCOL];

  assign chan[0] = r_i;
  assign chan[1] = g_i;
  assign chan[2] = b_i;

  for (genvar c = 0; c < NCOL; c++) begin : g_cf
    assign cf[c] = coef_i[c*COEF_W +: COEF_W];
  end

  // stage 1: products and aligned offset
  logic signed [PROD_W-1:0] s1_prod_q [NCOL-1];
  logic signed [ACC_W-1:0]  s1_off_q;
  logic                     s1_byp_q, s1_fmt_q;
  logic [PIX_W-1:0]         s1_pix_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NCOL-1; k++) s1_prod_q[k] <= '0;
      s1_off_q <= '0;
      s1_byp_q <= 1'b1;
      s1_fmt_q <= 1'b0;
      s1_pix_q <= '0;
    end else begin
      for (int k = 0; k < NCOL-1; k++)
        s1_prod_q[k] <= PROD_W'($signed({1'b0, chan[k]})) * PROD_W'(cf[k]);
      s1_off_q <= in_fmt ? (ACC_W'(cf[NCOL-1]) <<< FRAC_F1)
                         : (ACC_W'(cf[NCOL-1]) <<< FRAC_F0);
      s1_byp_q <= in_byp;
      s1_fmt_q <= in_fmt;
      s1_pix_q <= own_i;
    end
  end

  // stage 2: sum, round, scale
  logic signed [ACC_W-1:0] s2_sum;
  logic signed [ACC_W-1:0] s2_val_q;
  logic                    s2_byp_q;
  logic [PIX_W-1:0]        s2_pix_q;

  assign s2_sum = ACC_W'(s1_prod_q[0]) + ACC_W'(s1_prod_q[1]) + ACC_W'(s1_prod_q[2])
                + s1_off_q + (s1_fmt_q ? RND1 : RND0);

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_val_q <= '0;
      s2_byp_q <= 1'b1;
      s2_pix_q <= '0;
    end else begin
      s2_val_q <= s1_fmt_q ? (s2_sum >>> FRAC_F1) : (s2_sum >>> FRAC_F0);
      s2_byp_q <= s1_byp_q;
      s2_pix_q <= s1_pix_q;
    end
  end

  // stage 3: clamp and bypass select
  logic [PIX_W-1:0] clamped;

  always_comb begin
    if (s2_val_q < 0)             clamped = '0;
    else if (s2_val_q > PIX_MAX)  clamped = PIX_MAX[PIX_W-1:0];
    else                          clamped = s2_val_q[PIX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) pix_o <= '0;
    else     pix_o <= s2_byp_q ? s2_pix_q : clamped;
  end

endmodule

// File: rtl/ccm_matrix.sv
module ccm_matrix
  import ccm_pkg::*;
#(
  parameter int PIX_W   = 10,
  parameter int COEF_W  = 16,
  parameter int FRAC_F0 = 13,
  localparam int WORD_W = 2 * COEF_W,
  localparam int ADDR_W = $clog2(NCOEF / 2) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr_en,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  input  logic              frame_start,
  input  logic              pix_valid_i,
  input  logic [PIX_W-1:0]  pix_r_i,
  input  logic [PIX_W-1:0]  pix_g_i,
  input  logic [PIX_W-1:0]  pix_b_i,
  output logic              pix_valid_o,
  output logic [PIX_W-1:0]  pix_r_o,
  output logic [PIX_W-1:0]  pix_g_o,
  output logic [PIX_W-1:0]  pix_b_o
);
  localparam int FRAC_F1 = FRAC_F0 - 1;
  localparam int LAT     = 3;
  localparam int ROW_W   = NCOL * COEF_W;

  logic [NCOEF*COEF_W-1:0] coef_a, coef_b, coef_sel;
  logic [1:0]              req_mode;
  logic                    req_fmt;
  ccm_mode_e               act_mode;
  logic                    act_fmt;

  ccm_host_regs #(
    .COEF_W (COEF_W),
    .ADDR_W (ADDR_W)
  ) regs_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (host_wr_en),
    .addr     (host_addr),
    .wdata    (host_wdata),
    .cur_mode (act_mode),
    .rdata    (host_rdata),
    .coef_a   (coef_a),
    .coef_b   (coef_b),
    .req_mode (req_mode),
    .req_fmt  (req_fmt)
  );

  ccm_mode_sync sync_i (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .req_mode    (req_mode),
    .req_fmt     (req_fmt),
    .act_mode    (act_mode),
    .act_fmt     (act_fmt)
  );

  assign coef_sel = (act_mode == MODE_B) ? coef_b : coef_a;

  logic [PIX_W-1:0] own_pix [NROW];
  logic [PIX_W-1:0] row_out [NROW];

  assign own_pix[0] = pix_r_i;
  assign own_pix[1] = pix_g_i;
  assign own_pix[2] = pix_b_i;

  for (genvar r = 0; r < NROW; r++) begin : g_row
    ccm_mac_row #(
      .PIX_W   (PIX_W),
      .COEF_W  (COEF_W),
      .FRAC_F0 (FRAC_F0),
      .FRAC_F1 (FRAC_F1)
    ) row_i (
      .clk    (clk),
      .rst    (rst),
      .in_byp (act_mode == MODE_BYP),
      .in_fmt (act_fmt),
      .r_i    (pix_r_i),
      .g_i    (pix_g_i),
      .b_i    (pix_b_i),
      .own_i  (own_pix[r]),
      .coef_i (coef_sel[r*ROW_W +: ROW_W]),
      .pix_o  (row_out[r])
    );
  end

  logic [LAT-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else     vld_q <= {vld_q[LAT-2:0], pix_valid_i};
  end

  assign pix_valid_o = vld_q[LAT-1];
  assign pix_r_o     = row_out[0];
  assign pix_g_o     = row_out[1];
  assign pix_b_o     = row_out[2];

endmodule

// File: rtl/ccm_matrix_chk.sv
module ccm_matrix_chk #(
  parameter int PIX_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_start,
  input logic             pix_valid_i,
  input logic [PIX_W-1:0] pix_r_i,
  input logic             pix_valid_o,
  input logic [PIX_W-1:0] pix_r_o,
  input logic [1:0]       cur_mode,
  input logic [1:0]       req_mode
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= 2'd0;
    else if (since_rst != 3)  since_rst <= since_rst + 2'd1;
  end

  // R8
  valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (pix_valid_o == $past(pix_valid_i, 3)));

  // R10
  bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && pix_valid_o && $past(cur_mode, 3) == 2'd0)
      |-> (pix_r_o == $past(pix_r_i, 3)));

  // R4
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && !$past(frame_start)) |-> (cur_mode == $past(cur_mode)));

  // R4
  mode_take_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && $past(frame_start) && $past(req_mode) != 2'd3)
      |-> (cur_mode == $past(req_mode)));

  // R3
  reserved_byp_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && $past(frame_start) && $past(req_mode) == 2'd3)
      |-> (cur_mode == 2'd0));

endmodule

bind ccm_matrix ccm_matrix_chk #(.PIX_W(PIX_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .frame_start (frame_start),
  .pix_valid_i (pix_valid_i),
  .pix_r_i     (pix_r_i),
  .pix_valid_o (pix_valid_o),
  .pix_r_o     (pix_r_o),
  .cur_mode    (act_mode),
  .req_mode    (req_mode)
);

// File: tb/ccm_matrix_tb_top.sv
module ccm_matrix_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_W  = 10;
  localparam int COEF_W = 16;
  localparam int FRAC0  = 13;
  localparam int ADDR_W = 4;
  localparam int WORD_W = 32;
  localparam int MAXE   = 32768;

  logic              clk = 1'b0;
  logic              rst;
  logic              host_wr_en;
  logic [ADDR_W-1:0] host_addr;
  logic [WORD_W-1:0] host_wdata;
  logic [WORD_W-1:0] host_rdata;
  logic              frame_start;
  logic              pix_valid_i;
  logic [PIX_W-1:0]  pix_r_i, pix_g_i, pix_b_i;
  logic              pix_valid_o;
  logic [PIX_W-1:0]  pix_r_o, pix_g_o, pix_b_o;

  ccm_matrix #(.PIX_W(PIX_W), .COEF_W(COEF_W), .FRAC_F0(FRAC0)) dut_i (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .frame_start(frame_start),
    .pix_valid_i(pix_valid_i), .pix_r_i(pix_r_i), .pix_g_i(pix_g_i), .pix_b_i(pix_b_i),
    .pix_valid_o(pix_valid_o), .pix_r_o(pix_r_o), .pix_g_o(pix_g_o), .pix_b_o(pix_b_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0, wr_idx = 0, rd_idx = 0;
  int exp_r [MAXE];
  int exp_g [MAXE];
  int exp_b [MAXE];
  int exp_cyc [MAXE];
  string exp_tag [MAXE];

  int coef_m [2][12];
  int req_mode = 0, req_fmt = 0, act_mode = 0, act_fmt = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, string what, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  function automatic int model(int bank, int fmt, int ch, int r, int g, int b);
    longint acc;
    int f;
    f = fmt ? FRAC0 - 1 : FRAC0;
    acc = longint'(r) * coef_m[bank][4*ch] + longint'(g) * coef_m[bank][4*ch+1]
        + longint'(b) * coef_m[bank][4*ch+2]
        + (longint'(coef_m[bank][4*ch+3]) <<< f) + (longint'(1) <<< (f - 1));
    acc = acc >>> f;
    if (acc < 0) acc = 0;
    if (acc > 1023) acc = 1023;
    return int'(acc);
  endfunction

  function automatic logic [31:0] pack(int bank, int k);
    logic [15:0] lo, hi;
    lo = coef_m[bank][2*k][15:0];
    hi = coef_m[bank][2*k+1][15:0];
    return {hi, lo};
  endfunction

  task automatic record(int r, int g, int b, string tag);
    if (act_mode == 0) begin
      exp_r[wr_idx] = r; exp_g[wr_idx] = g; exp_b[wr_idx] = b;
    end else begin
      exp_r[wr_idx] = model(act_mode - 1, act_fmt, 0, r, g, b);
      exp_g[wr_idx] = model(act_mode - 1, act_fmt, 1, r, g, b);
      exp_b[wr_idx] = model(act_mode - 1, act_fmt, 2, r, g, b);
    end
    exp_cyc[wr_idx] = cyc;
    exp_tag[wr_idx] = tag;
    wr_idx++;
  endtask

  task automatic send(int r, int g, int b, string tag);
    pix_r_i = PIX_W'(r); pix_g_i = PIX_W'(g); pix_b_i = PIX_W'(b);
    pix_valid_i = 1'b1;
    record(r, g, b, tag);
    @(negedge clk);
    pix_valid_i = 1'b0;
  endtask

  task automatic apply_frame();
    act_mode = (req_mode == 3) ? 0 : req_mode;
    act_fmt  = req_fmt;
  endtask

  task automatic frame_pulse();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    apply_frame();
  endtask

  // pixel alongside frame_start: expected with old settings (R4)
  task automatic send_fs(int r, int g, int b);
    frame_start = 1'b1;
    pix_r_i = PIX_W'(r); pix_g_i = PIX_W'(g); pix_b_i = PIX_W'(b);
    pix_valid_i = 1'b1;
    record(r, g, b, "R4");
    @(negedge clk);
    frame_start = 1'b0;
    pix_valid_i = 1'b0;
    apply_frame();
  endtask

  task automatic hwrite(int addr, logic [31:0] data);
    host_addr = ADDR_W'(addr); host_wdata = data; host_wr_en = 1'b1;
    @(negedge clk);
    host_wr_en = 1'b0;
    if (addr == 14) begin
      req_mode = int'(data[1:0]);
      req_fmt  = int'(data[4]);
    end
  endtask

  task automatic hread(int addr, output logic [31:0] data);
    host_addr = ADDR_W'(addr);
    @(negedge clk);
    data = host_rdata;
  endtask

  task automatic write_bank(int bank);
    for (int k = 0; k < 6; k++) hwrite(bank*8 + k, pack(bank, k));
  endtask

  task automatic check_ctrl(string tag);
    logic [31:0] d, e;
    hread(14, d);
    e = 32'((act_mode << 8) | (req_fmt << 4) | req_mode);
    check(d == e, tag, "control readback", d, e);
  endtask

  task automatic sweep(int step, string tag);
    for (int r = 0; r < 1024; r += step)
      for (int g = 0; g < 1024; g += step)
        for (int b = 0; b < 1024; b += step)
          send(r, g, b, tag);
  endtask

  task automatic drain();
    repeat (6) @(negedge clk);
    check(rd_idx == wr_idx, "R8", "pixels out vs in", rd_idx, wr_idx);
  endtask

  always @(negedge clk) begin
    if (!rst && pix_valid_o) begin
      if (rd_idx >= wr_idx) begin
        check(1'b0, "R8", "unexpected output valid", rd_idx, wr_idx);
      end else begin
        check(int'(pix_r_o) == exp_r[rd_idx], exp_tag[rd_idx], "red", pix_r_o, exp_r[rd_idx]);
        check(int'(pix_g_o) == exp_g[rd_idx], exp_tag[rd_idx], "green", pix_g_o, exp_g[rd_idx]);
        check(int'(pix_b_o) == exp_b[rd_idx], exp_tag[rd_idx], "blue", pix_b_o, exp_b[rd_idx]);
        check(cyc - exp_cyc[rd_idx] == 3, "R8", "latency", cyc - exp_cyc[rd_idx], 3);
        rd_idx++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst = 1'b1; host_wr_en = 1'b0; host_addr = '0; host_wdata = '0;
    frame_start = 1'b0; pix_valid_i = 1'b0;
    pix_r_i = '0; pix_g_i = '0; pix_b_i = '0;
    coef_m[0] = '{4096, 4096, 0, 0,  -8192, 16383, 0, 50,  2731, 2731, 2730, -5};
    coef_m[1] = '{0, 0, 8192, 0,  12000, -3000, -1000, 300,  -32768, 0, 0, 1100};
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check(pix_valid_o == 0 && pix_r_o == 0 && pix_g_o == 0 && pix_b_o == 0,
          "R1", "outputs after reset", {pix_valid_o, pix_r_o}, 0);
    check_ctrl("R1");
    for (int a = 0; a < 16; a++) begin
      hread(a, d);
      check(d == 0, "R1", "register after reset", d, 0);
    end

    // R2 packing and readback, both banks; idle-bank writes while bypass
    write_bank(0);
    write_bank(1);
    for (int bk = 0; bk < 2; bk++)
      for (int k = 0; k < 6; k++) begin
        hread(bk*8 + k, d);
        check(d == pack(bk, k), "R2", "coefficient word", d, pack(bk, k));
      end
    hwrite(6, 32'hFFFF_FFFF);
    hwrite(15, 32'hFFFF_FFFF);
    hread(6, d);  check(d == 0, "R2", "addr 6 reads zero", d, 0);
    hread(15, d); check(d == 0, "R2", "addr 15 reads zero", d, 0);
    hread(0, d);  check(d == pack(0, 0), "R2", "word 0 after stray write", d, pack(0, 0));

    // R10 bypass sweep, including top code
    sweep(146, "R10");
    send(1023, 1023, 1023, "R10");
    drain();

    // R4 request without frame_start has no effect
    hwrite(14, 32'h1);
    check_ctrl("R4");
    send(700, 300, 20, "R4");
    send(1023, 0, 512, "R4");
    frame_pulse();
    check_ctrl("R4");

    // R5 R7 bank A, format 0
    sweep(73, "R5");
    send(0, 1023, 0, "R7");
    send(1023, 0, 0, "R7");
    send(1, 0, 0, "R5");
    send(3, 0, 0, "R5");
    drain();

    // R9 rewrite idle bank B while A streams
    coef_m[1] = '{0, 0, 8192, 0,  12000, -3000, -1000, 300,  -32768, 0, 0, 1100};
    for (int k = 0; k < 6; k++) begin
      send(k*150, 1023 - k*150, 511, "R9");
      hwrite(8 + k, pack(1, k));
      send(k*170 + 3, k*40, 1000 - k*90, "R9");
    end
    drain();

    // R3 bank B, format 0; R4 pixel on the switching edge keeps bank A
    hwrite(14, 32'h2);
    send(400, 401, 402, "R4");
    send_fs(801, 33, 999);
    check_ctrl("R3");
    sweep(73, "R3");
    drain();

    // R6 format 1 on bank B
    hwrite(14, 32'h12);
    frame_pulse();
    check_ctrl("R6");
    sweep(93, "R6");
    send(1023, 1023, 1023, "R6");
    drain();

    // R6 format 1 on bank A
    hwrite(14, 32'h11);
    frame_pulse();
    sweep(146, "R6");
    drain();

    // R3 reserved mode acts as bypass, current field reports 0
    hwrite(14, 32'h3);
    frame_pulse();
    check_ctrl("R3");
    sweep(205, "R3");
    drain();

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule